// File: doc/BRIEF.md
# Instruction-Driven I/O Sequencer with Host Instruction Injection

This block is a small programmable I/O engine. A sequencer steps through 16-bit words held in a 32-entry program store. It supports a reduced set of operations: load an immediate into scratch register X, stall on the level of a GPIO pin, shift bits of X into an input shift register (ISR), move the ISR into a 4-entry receive queue, and jump.

A programmable address window makes the program loop. When an instruction at the window's top address completes without jumping, the program counter returns to the window's bottom address.

A host port can place a single instruction into the next execution slot in place of the fetched word. This injected instruction does not move the program counter. A program that was stalled on a pin therefore goes back to the same stall after the injected instruction finishes, instead of dropping through to the next step. An injected jump is the only way the host port moves the program counter. The host reads captured words from the head of the receive queue.

Top module: `prog_io_sm`

## Requirements
- R1: After synchronous reset, `pc_dbg` is 0, `x_dbg` is 0, `rx_level` is 0 and `rx_empty` is 1.
- R2: A word with bits [15:13]=111, [7:5]=001 and [4:0]=v loads X with v zero-extended. When fetched from the program store, it advances the PC. For example, 16'hE028 leaves X at 8.
- R3: A word with bits [15:13]=001, bit 7 = polarity p, [6:5]=00 and [4:0]=pin n keeps the PC unchanged on every cycle while `gpio_in[n]` differs from p. Once the pin matches, the PC advances.
- R4: A word with bits [15:13]=010, [7:5]=000 and [4:0]=count c shifts the low c bits of X into the ISR from the LSB side (ISR = ISR<<c | X[c-1:0]), where c=0 means 32. A word with bits [15:13]=100 and bit 7=0 appends the ISR to the receive queue, clears the ISR and raises `rx_level` by one.
- R5: The receive queue holds 4 words and presents its oldest word on `rx_data`. `rx_rd` removes that word. A push while the queue is full keeps the PC on the push until a slot frees.
- R6: A word written with `frc_we` executes in the next enabled cycle instead of the fetched word. If it is not a jump, the PC is unchanged afterwards.
- R7: If an instruction is injected while a pin wait is stalled, the PC stays on the wait and the wait is evaluated again afterwards. No step is skipped and nothing is pushed.
- R8: An injected jump (bits [15:13]=000, target [4:0]) sets the PC to the target, and the program continues from there.
- R9: After a non-jump instruction at `wrap_top` completes, the PC becomes `wrap_bot`.
- R10: While `en` is 0 nothing executes, and an injected word stays pending. It executes in the first enabled cycle.
- R11: An injected instruction that stalls (for example, a pin wait) keeps occupying the execution slot until it completes. Only then does the fetched program resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execution enable |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | 5 | Program store write address |
| prog_data | input | 16 | Program store write word |
| wrap_bot | input | 5 | Loop window bottom address |
| wrap_top | input | 5 | Loop window top address |
| gpio_in | input | 32 | GPIO input levels |
| frc_we | input | 1 | Injected instruction write strobe |
| frc_data | input | 16 | Injected instruction word |
| rx_rd | input | 1 | Pop the receive queue head |
| rx_data | output | 32 | Receive queue head word |
| rx_level | output | 3 | Receive queue fill level |
| rx_empty | output | 1 | Receive queue empty |
| pc_dbg | output | 5 | Current program counter |
| x_dbg | output | 32 | Current X register |

## Verification
A PC that advances wrongly after an injected word shows up within a few cycles. After the next pin pulse, `pc_dbg` leaves the wait address early, or the queue gains a word with no pulse at all. An injected word that is lost, or executed twice, shows up one cycle after its slot as a wrong `x_dbg` value, or later as an unexpected word at `rx_data`. ISR or queue corruption appears only at the next push, when the head word and `rx_level` differ from the values the bench predicts from the sequence of X values.

// File: rtl/prog_io_sm_pkg.sv
package prog_io_sm_pkg;

    localparam int WORD_W  = 32;
    localparam int INSTR_W = 16;

    typedef enum logic [2:0] {
        OP_JMP  = 3'b000,
        OP_WAIT = 3'b001,
        OP_IN   = 3'b010,
        OP_PUSH = 3'b100,
        OP_SET  = 3'b111
    } op_e;

    typedef struct packed {
        op_e        op;
        logic       flag;   // bit 7: wait polarity / push variant
        logic [1:0] sel;    // bits 6:5: wait source
        logic [2:0] field;  // bits 7:5: destination / source
        logic [4:0] arg;    // bits 4:0: immediate / pin / count / target
    } dec_t;

    function automatic dec_t decode(input logic [INSTR_W-1:0] w);
        dec_t d;
        d.op    = op_e'(w[15:13]);
        d.flag  = w[7];
        d.sel   = w[6:5];
        d.field = w[7:5];
        d.arg   = w[4:0];
        return d;
    endfunction

    // Shift 'cnt' low bits of src into isr from the LSB side; cnt 0 means full word
    function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] isr,
                                                   input logic [WORD_W-1:0] src,
                                                   input logic [4:0]        cnt);
        logic [5:0]        n;
        logic [WORD_W-1:0] mask;
        n    = (cnt == 5'd0) ? 6'd32 : {1'b0, cnt};
        mask = (n == 6'd32) ? '1 : ((WORD_W'(1) << n) - WORD_W'(1));
        return (n == 6'd32) ? src : ((isr << n) | (src & mask));
    endfunction

endpackage

// File: rtl/prog_io_sm_imem.sv
module prog_io_sm_imem #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/prog_io_sm_rxq.sv
module prog_io_sm_rxq #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [LW-1:0]    level_o,
    output logic             full_o,
    output logic             empty_o
);
    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             pop_eff;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty_o = (level_o == '0);
    assign full_o  = (level_o == LW'(DEPTH));
    assign pop_eff = pop_i && !empty_o;
    assign head_o  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_i) slots[wr_ptr] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_o <= '0;
        end else begin
            if (push_i)  wr_ptr <= bump(wr_ptr);
            if (pop_eff) rd_ptr <= bump(rd_ptr);
            if (push_i && !pop_eff)      level_o <= level_o + LW'(1);
            else if (!push_i && pop_eff) level_o <= level_o - LW'(1);
        end
    end

    // R5: the sequencer must stall instead of pushing into a full queue
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        !(push_i && full_o));

    // R4: a push without a pop raises the level by exactly one
    p_level_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_eff) |=> (level_o == LW'($past(level_o) + LW'(1))));
endmodule

// File: rtl/prog_io_sm_inject.sv
module prog_io_sm_inject #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             done_i,
    output logic             pend_o,
    output logic [WIDTH-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= 1'b0;
            word_o <= '0;
        end else if (wr_i) begin
            pend_o <= 1'b1;
            word_o <= wr_data_i;
        end else if (done_i) begin
            pend_o <= 1'b0;
        end
    end

    // R10: a pending word survives any number of disabled cycles
    p_hold_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !en) |=> pend_o);
endmodule

// File: rtl/prog_io_sm.sv
module prog_io_sm
    import prog_io_sm_pkg::*;
#(
    parameter int IMEM_DEPTH = 32,
    parameter int RXQ_DEPTH  = 4,
    parameter int GPIO_W     = 32,
    localparam int PC_W      = $clog2(IMEM_DEPTH),
    localparam int LVL_W     = $clog2(RXQ_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic [PC_W-1:0]    wrap_bot,
    input  logic [PC_W-1:0]    wrap_top,
    input  logic [GPIO_W-1:0]  gpio_in,
    input  logic               frc_we,
    input  logic [INSTR_W-1:0] frc_data,
    input  logic               rx_rd,
    output logic [WORD_W-1:0]  rx_data,
    output logic [LVL_W-1:0]   rx_level,
    output logic               rx_empty,
    output logic [PC_W-1:0]    pc_dbg,
    output logic [WORD_W-1:0]  x_dbg
);
    logic [PC_W-1:0]    pc;
    logic [WORD_W-1:0]  x_q, isr_q;
    logic [INSTR_W-1:0] fetched, inj_word, instr;
    logic               inj_pend, inj_done;
    logic               q_full;
    dec_t               d;

    logic               stall, jump, x_we, isr_we, push_ok;
    logic               unused_bits;

    prog_io_sm_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) u_imem (
        .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
        .raddr(pc), .rdata(fetched)
    );

    prog_io_sm_inject #(.WIDTH(INSTR_W)) u_inject (
        .clk(clk), .rst(rst), .en(en), .wr_i(frc_we), .wr_data_i(frc_data),
        .done_i(inj_done), .pend_o(inj_pend), .word_o(inj_word)
    );

    prog_io_sm_rxq #(.DEPTH(RXQ_DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk(clk), .rst(rst), .push_i(en && push_ok), .push_data_i(isr_q),
        .pop_i(rx_rd), .head_o(rx_data), .level_o(rx_level),
        .full_o(q_full), .empty_o(rx_empty)
    );

    // Injected word takes the slot whenever one is pending
    assign instr       = inj_pend ? inj_word : fetched;
    assign d           = decode(instr);
    assign unused_bits = ^instr[12:8];

    always_comb begin
        stall   = 1'b0;
        jump    = 1'b0;
        x_we    = 1'b0;
        isr_we  = 1'b0;
        push_ok = 1'b0;
        case (d.op)
            OP_JMP:  jump = 1'b1;
            OP_WAIT: if (d.sel == 2'b00 && gpio_in[d.arg] != d.flag) stall = 1'b1;
            OP_IN:   if (d.field == 3'b000) isr_we = 1'b1;
            OP_PUSH: if (!d.flag) begin
                         if (q_full) stall = 1'b1;
                         else        push_ok = 1'b1;
                     end
            OP_SET:  if (d.field == 3'b001) x_we = 1'b1;
            default: ;
        endcase
    end

    assign inj_done = en && inj_pend && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            x_q   <= '0;
            isr_q <= '0;
        end else if (en) begin
            if (jump)
                pc <= d.arg[PC_W-1:0];
            else if (!stall && !inj_pend)
                pc <= (pc == wrap_top) ? wrap_bot : pc + PC_W'(1);
            if (x_we)        x_q   <= {{(WORD_W-5){1'b0}}, d.arg};
            if (isr_we)      isr_q <= shift_in(isr_q, x_q, d.arg);
            else if (push_ok) isr_q <= '0;
        end
    end

    assign pc_dbg = pc;
    assign x_dbg  = x_q;

    // R3: an unsatisfied fetched pin wait holds the PC
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !inj_pend && d.op == OP_WAIT && d.sel == 2'b00 &&
         gpio_in[d.arg] != d.flag) |=> $stable(pc));

    // R6: a non-jump injected instruction leaves the PC where it was
    p_inject_pc_r6: assert property (@(posedge clk) disable iff (rst)
        (en && inj_pend && d.op != OP_JMP) |=> $stable(pc));

    // R10: nothing changes while disabled
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(pc) && $stable(x_q)));
endmodule

// File: tb/prog_io_sm_bench.sv
module prog_io_sm_bench;
    logic        clk = 1'b0;
    logic        rst, en, prog_we, frc_we, rx_rd;
    logic [4:0]  prog_addr, wrap_bot, wrap_top;
    logic [15:0] prog_data, frc_data;
    logic [31:0] gpio_in;
    logic [31:0] rx_data, x_dbg;
    logic [2:0]  rx_level;
    logic        rx_empty;
    logic [4:0]  pc_dbg;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    prog_io_sm u_prog_io_sm (
        .clk(clk), .rst(rst), .en(en), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .wrap_bot(wrap_bot), .wrap_top(wrap_top),
        .gpio_in(gpio_in), .frc_we(frc_we), .frc_data(frc_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_level(rx_level), .rx_empty(rx_empty),
        .pc_dbg(pc_dbg), .x_dbg(x_dbg)
    );

    function automatic logic [15:0] enc_set(input logic [4:0] v);  return 16'hE020 | {11'd0, v}; endfunction
    function automatic logic [15:0] enc_wait(input logic p, input logic [4:0] n); return 16'h2000 | {8'd0, p, 2'b00, n}; endfunction
    function automatic logic [15:0] enc_in(input logic [4:0] c);   return 16'h4000 | {11'd0, c}; endfunction
    function automatic logic [15:0] enc_push();                    return 16'h8000; endfunction
    function automatic logic [15:0] enc_jmp(input logic [4:0] t);  return {11'd0, t}; endfunction
    function automatic logic [31:0] model_in(input logic [31:0] isr, input logic [31:0] x, input int c);
        int n = (c == 0) ? 32 : c;
        if (n == 32) return x;
        return (isr << n) | (x & ((32'd1 << n) - 1));
    endfunction

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic load(input logic [4:0] a, input logic [15:0] w);
        prog_we = 1'b1; prog_addr = a; prog_data = w;
        tick();
        prog_we = 1'b0;
    endtask

    task automatic inject(input logic [15:0] w);
        frc_we = 1'b1; frc_data = w;
        tick();
        frc_we = 1'b0;
        tick();
    endtask

    task automatic pop();
        rx_rd = 1'b1;
        tick();
        rx_rd = 1'b0;
    endtask

    task automatic pulse0();
        gpio_in[0] = 1'b1;
        tick();
        gpio_in[0] = 1'b0;
        tick(6);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] v0, v, w;
        logic [31:0] isr_m;
        void'($urandom(32'd1234));
        rst = 1'b1; en = 1'b0; prog_we = 1'b0; frc_we = 1'b0; rx_rd = 1'b0;
        prog_addr = '0; prog_data = '0; frc_data = '0; gpio_in = '0;
        wrap_bot = 5'd0; wrap_top = 5'd3;
        tick(3);
        rst = 1'b0;
        tick();
        chk("R1 pc", 32'(pc_dbg), 0);
        chk("R1 x", x_dbg, 0);
        chk("R1 level", 32'(rx_level), 0);
        chk("R1 empty", 32'(rx_empty), 1);

        v0 = 5'd3;
        load(0, enc_set(v0));
        load(1, enc_wait(1'b1, 5'd0));
        load(2, enc_in(5'd0));
        load(3, enc_push());
        load(4, enc_jmp(5'd4));
        en = 1'b1;
        tick(4);
        chk("R2 x after set", x_dbg, 32'(v0));
        chk("R3 pc held on wait", 32'(pc_dbg), 1);

        // injection during stalled wait: 0xE028 sets X to 8
        inject(16'hE028);
        chk("R6 x after injected set", x_dbg, 8);
        chk("R6 pc unchanged", 32'(pc_dbg), 1);
        tick(3);
        chk("R7 pc stays on wait", 32'(pc_dbg), 1);
        chk("R7 nothing pushed", 32'(rx_level), 0);
        pulse0();
        chk("R4 level after push", 32'(rx_level), 1);
        chk("R4 pushed X", rx_data, 8);
        chk("R9 wrapped and reloaded x", x_dbg, 32'(v0));
        chk("R3 back on wait", 32'(pc_dbg), 1);
        pop();
        chk("R5 pop empties", 32'(rx_empty), 1);

        // injected jump
        inject(enc_jmp(5'd4));
        chk("R8 pc at target", 32'(pc_dbg), 4);
        tick(3);
        chk("R8 program continues at target", 32'(pc_dbg), 4);
        inject(enc_jmp(5'd0));
        tick(3);
        chk("R8 restart reaches wait", 32'(pc_dbg), 1);

        // injected stalling wait on pin 1
        inject(enc_wait(1'b1, 5'd1));
        gpio_in[0] = 1'b1;
        tick(4);
        chk("R11 injected wait blocks", 32'(pc_dbg), 1);
        chk("R11 no push while blocked", 32'(rx_level), 0);
        gpio_in[1] = 1'b1;
        tick(20);
        gpio_in[0] = 1'b0;
        gpio_in[1] = 1'b0;
        tick(2);
        chk("R5 full queue level", 32'(rx_level), 4);
        chk("R5 stalled on push", 32'(pc_dbg), 3);
        pop();
        tick(4);
        chk("R5 push resumed", 32'(rx_level), 4);
        chk("R5 back on wait", 32'(pc_dbg), 1);
        for (int i = 0; i < 4; i++) begin
            chk("R5 drained word", rx_data, 32'(v0));
            pop();
        end
        chk("R5 drained empty", 32'(rx_empty), 1);

        // partial-width shifts through injection
        isr_m = 32'd0;
        inject(enc_set(5'd21));
        inject(enc_in(5'd3));
        isr_m = model_in(isr_m, 32'd21, 3);
        inject(enc_set(5'd6));
        inject(enc_in(5'd2));
        isr_m = model_in(isr_m, 32'd6, 2);
        inject(enc_push());
        chk("R4 partial shift word", rx_data, isr_m);
        chk("R4 partial shift level", 32'(rx_level), 1);
        chk("R6 pc after injected sequence", 32'(pc_dbg), 1);
        pop();

        // disabled: injection held pending
        en = 1'b0;
        frc_we = 1'b1; frc_data = enc_set(5'd17);
        tick();
        frc_we = 1'b0;
        tick(4);
        chk("R10 x unchanged while disabled", x_dbg, 6);
        chk("R10 pc unchanged while disabled", 32'(pc_dbg), 1);
        en = 1'b1;
        tick();
        chk("R10 pending executes on enable", x_dbg, 17);
        chk("R10 pc after enable", 32'(pc_dbg), 1);

        // random rounds
        for (int k = 0; k < 10; k++) begin
            v = 5'($urandom);
            w = 5'($urandom);
            load(0, enc_set(v));
            inject(enc_set(w));
            chk("R6 random injected x", x_dbg, 32'(w));
            pulse0();
            chk("R4 random pushed word", rx_data, 32'(w));
            chk("R4 random level", 32'(rx_level), 1);
            chk("R9 random wrap reload", x_dbg, 32'(v));
            chk("R7 random pc", 32'(pc_dbg), 1);
            pop();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule